// File: doc/BRIEF.md
# Receive Buffer Descriptor Engine

This block takes received Ethernet frames from a byte stream and places them into memory through a ring of 8-byte receive descriptors. Each frame is first held whole in an internal store while its CRC-32 is accumulated. Once the last byte has arrived, the engine scatters the payload and the four CRC bytes across as many descriptors as needed. It then writes back each descriptor's length and status and walks the ring.

A descriptor is two big-endian 32-bit words. The word at offset 0 carries a 16-bit status halfword in bits 31:16 and a 16-bit length in bits 15:0. The word at offset 4 holds the buffer address. Status bit 15 means "empty, owned by the engine", bit 13 means "wrap to ring start after this one", bit 11 marks the final buffer of a frame, bit 5 flags a length violation and bit 0 flags truncation.

Software sets up the ring and loads the ring pointer with a restart pulse. It then pulses a kick so that the engine looks at the current descriptor. The engine accepts input only while its receive-active status is high. That status is recomputed from the next descriptor after every frame.

Top module: `rx_bd_engine`

## Requirements
- R1: After reset, rx_active, in_ready, mem_req, ev_rx_buf and ev_rx_frame are all low.
- R2: A rx_kick pulse while rx_active is low reads the status word at the ring pointer, and rx_active becomes that word's bit 15 (bit 31 of the read data). in_ready is high only while rx_active is high and no memory activity is pending.
- R3: The stored byte sequence is the payload followed by the Ethernet CRC-32 of the payload. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. Its bits 31:24 are stored first. Data bytes go one per transfer to byte addresses, and byte-address offset 0 of a word is lane bits 31:24.
- R4: The stored size is the payload length plus 4. Each descriptor gets min(remaining bytes, buf_size) bytes, and that count is written to its length halfword (offset 2). The CRC bytes may therefore span two buffers.
- R5: Write-back clears bit 15 of every used descriptor and keeps its other status bits. The final descriptor of a frame also gets bit 11, plus bit 0 and bit 5 when those errors apply.
- R6: ev_rx_buf pulses once per non-final descriptor written back, and ev_rx_frame pulses once per final descriptor.
- R7: After a write-back, the ring pointer goes to ring_base if the descriptor's bit 13 is set, and otherwise moves on by 8.
- R8: A stored size above MAX_FRAME (2032) is cut to MAX_FRAME bytes, made of the first MAX_FRAME-4 payload bytes plus the CRC. Bits 0 and 5 are then set on the final descriptor.
- R9: A stored size greater than frame_limit sets bit 5 without truncation. A size equal to frame_limit sets nothing.
- R10: If the descriptor at the ring pointer is not empty while a frame is being written, the rest of that frame is dropped and rx_active goes low.
- R11: After every frame, the engine reads the status word at the new ring pointer and sets rx_active from its bit 15.
- R12: A ring_restart pulse while idle loads the ring pointer from ring_base.
- R13: Once mem_req is raised, mem_req, mem_we, mem_addr, mem_wdata and mem_be stay stable until the cycle in which mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of the first descriptor of the ring |
| buf_size | input | BW | Largest number of bytes placed in one buffer (nonzero) |
| frame_limit | input | 16 | Stored size above which bit 5 is set |
| ring_restart | input | 1 | Load ring pointer from ring_base |
| rx_kick | input | 1 | Re-check the current descriptor while inactive |
| rx_active | output | 1 | Next descriptor is empty; reception allowed |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_be | output | 4 | Byte lanes written, bit 3 is bits 31:24 |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ev_rx_buf | output | 1 | One-cycle pulse per non-final buffer completed |
| ev_rx_frame | output | 1 | One-cycle pulse per completed frame |

## Verification
Most internal faults surface in the memory image. A wrong ring pointer, chunk count or CRC byte selection shows as a misplaced or altered byte, or a wrong status halfword, as soon as the frame's write-back finishes. The bench compares every byte of the memory against a model after each frame. A wrong receive-active flag shows at in_ready one probe read after the frame. Event counts reveal a misclassified final descriptor in the cycle after its write-back.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
    localparam int FL_EMPTY    = 15;
    localparam int FL_WRAP     = 13;
    localparam int FL_LAST     = 11;
    localparam int FL_LONG     = 5;
    localparam int FL_TRUNC    = 0;
    localparam int DESC_STRIDE = 8;
    localparam int PTR_OFS     = 4;
    localparam int FCS_BYTES   = 4;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SIZE, SQ_HEAD, SQ_PTR, SQ_DATA, SQ_BACK, SQ_PROBE
    } seq_state_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [3:0] lane_of(input logic [1:0] a);
        return 4'b1000 >> a;
    endfunction
endpackage

// File: rtl/rxbd_crc.sv
module rxbd_crc
    import rxbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '1;
        else if (en)      acc <= crc_step(acc, din);
    end

    assign fcs = ~acc;
endmodule

// File: rtl/rxbd_store.sv
module rxbd_store #(
    parameter int DEPTH = 2028,
    parameter int CW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [7:0]    din,
    input  logic [CW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count
);
    localparam int IW = $clog2(DEPTH);
    logic [7:0] mem [DEPTH];

    // count saturates one above DEPTH so an overlong frame stays visible
    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else if (wr_en && count <= CW'(DEPTH)) count <= count + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en && count < CW'(DEPTH)) mem[count[IW-1:0]] <= din;
    end

    assign rd_byte = (rd_idx < CW'(DEPTH)) ? mem[rd_idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
    import rxbd_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int CW        = 11,
    parameter int BW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   ring_base,
    input  logic [BW-1:0] buf_size,
    input  logic [15:0]   frame_limit,
    input  logic          ring_restart,
    input  logic          rx_kick,
    input  logic          frame_done,
    input  logic [CW-1:0] pay_count,
    input  logic [7:0]    pay_byte,
    input  logic [31:0]   fcs,
    output logic [CW-1:0] rd_idx,
    output logic          flush,
    output logic          active,
    output logic          idle,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          ev_buf,
    output logic          ev_frame
);
    localparam int DEPTH = MAX_FRAME - FCS_BYTES;

    seq_state_t    st;
    logic [31:0]   ring_ptr, data_ptr;
    logic [CW-1:0] pos, total, chunk_len, chunk_cnt;
    logic [15:0]   head_flags;
    logic          err_trunc, err_long;

    logic [CW-1:0] remain, chunk_next, pay_len;
    logic [1:0]    fsel;
    logic [7:0]    fbyte, out_byte;
    logic [15:0]   wb_flags;
    logic          final_piece;

    assign remain      = total - pos;
    assign pay_len     = total - CW'(FCS_BYTES);
    assign final_piece = (pos == total);
    assign chunk_next  = (32'(remain) < 32'(buf_size)) ? remain : CW'(buf_size);
    assign fsel        = 2'(pos - pay_len);
    assign rd_idx      = pos;
    assign idle        = (st == SQ_IDLE);
    assign flush       = (st == SQ_PROBE) && mem_ack;

    always_comb begin
        case (fsel)
            2'd0:    fbyte = fcs[31:24];
            2'd1:    fbyte = fcs[23:16];
            2'd2:    fbyte = fcs[15:8];
            default: fbyte = fcs[7:0];
        endcase
        out_byte = (pos < pay_len) ? pay_byte : fbyte;
    end

    always_comb begin
        wb_flags = head_flags;
        wb_flags[FL_EMPTY] = 1'b0;
        if (final_piece) begin
            wb_flags[FL_LAST] = 1'b1;
            if (err_trunc) wb_flags[FL_TRUNC] = 1'b1;
            if (err_long)  wb_flags[FL_LONG]  = 1'b1;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ring_ptr;
        mem_be    = 4'hF;
        mem_wdata = '0;
        unique case (st)
            SQ_HEAD, SQ_PROBE: mem_req = 1'b1;
            SQ_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ring_ptr + 32'(PTR_OFS);
            end
            SQ_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_ptr;
                mem_be    = lane_of(data_ptr[1:0]);
                mem_wdata = {4{out_byte}};
            end
            SQ_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {wb_flags, 16'(chunk_len)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            active     <= 1'b0;
            ring_ptr   <= '0;
            data_ptr   <= '0;
            pos        <= '0;
            total      <= '0;
            chunk_len  <= '0;
            chunk_cnt  <= '0;
            head_flags <= '0;
            err_trunc  <= 1'b0;
            err_long   <= 1'b0;
            ev_buf     <= 1'b0;
            ev_frame   <= 1'b0;
        end else begin
            ev_buf   <= 1'b0;
            ev_frame <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (frame_done) st <= SQ_SIZE;
                    else begin
                        if (ring_restart) ring_ptr <= ring_base;
                        if (rx_kick && !active) st <= SQ_PROBE;
                    end
                end
                SQ_SIZE: begin
                    pos <= '0;
                    if (pay_count > CW'(DEPTH)) begin
                        total     <= CW'(MAX_FRAME);
                        err_trunc <= 1'b1;
                        err_long  <= 1'b1;
                    end else begin
                        total     <= pay_count + CW'(FCS_BYTES);
                        err_trunc <= 1'b0;
                        err_long  <= (32'(pay_count) + 32'(FCS_BYTES)) > 32'(frame_limit);
                    end
                    st <= SQ_HEAD;
                end
                SQ_HEAD: if (mem_ack) begin
                    if (mem_rdata[16+FL_EMPTY]) begin
                        head_flags <= mem_rdata[31:16];
                        chunk_len  <= chunk_next;
                        chunk_cnt  <= '0;
                        st         <= SQ_PTR;
                    end else begin
                        st <= SQ_PROBE;
                    end
                end
                SQ_PTR: if (mem_ack) begin
                    data_ptr <= mem_rdata;
                    st       <= SQ_DATA;
                end
                SQ_DATA: if (mem_ack) begin
                    data_ptr  <= data_ptr + 32'd1;
                    pos       <= pos + CW'(1);
                    chunk_cnt <= chunk_cnt + CW'(1);
                    if (chunk_cnt + CW'(1) == chunk_len) st <= SQ_BACK;
                end
                SQ_BACK: if (mem_ack) begin
                    ev_frame <= final_piece;
                    ev_buf   <= !final_piece;
                    ring_ptr <= wb_flags[FL_WRAP] ? ring_base : ring_ptr + 32'(DESC_STRIDE);
                    st       <= final_piece ? SQ_PROBE : SQ_HEAD;
                end
                SQ_PROBE: if (mem_ack) begin
                    active <= mem_rdata[16+FL_EMPTY];
                    st     <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_bd_engine.sv
module rx_bd_engine
    import rxbd_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int BW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   ring_base,
    input  logic [BW-1:0] buf_size,
    input  logic [15:0]   frame_limit,
    input  logic          ring_restart,
    input  logic          rx_kick,
    output logic          rx_active,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          ev_rx_buf,
    output logic          ev_rx_frame
);
    localparam int DEPTH = MAX_FRAME - FCS_BYTES;
    localparam int CW    = $clog2(MAX_FRAME + 1);

    logic          accept, frame_done, flush, seq_idle;
    logic [31:0]   fcs;
    logic [CW-1:0] rd_idx, pay_count;
    logic [7:0]    pay_byte;

    assign in_ready   = rx_active && seq_idle;
    assign accept     = in_valid && in_ready;
    assign frame_done = accept && in_last;

    rxbd_crc u_crc (
        .clk(clk), .rst(rst), .clear(flush), .en(accept), .din(in_data), .fcs(fcs)
    );

    rxbd_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst(rst), .clear(flush), .wr_en(accept), .din(in_data),
        .rd_idx(rd_idx), .rd_byte(pay_byte), .count(pay_count)
    );

    rxbd_seq #(.MAX_FRAME(MAX_FRAME), .CW(CW), .BW(BW)) u_seq (
        .clk(clk), .rst(rst), .ring_base(ring_base), .buf_size(buf_size),
        .frame_limit(frame_limit), .ring_restart(ring_restart), .rx_kick(rx_kick),
        .frame_done(frame_done), .pay_count(pay_count), .pay_byte(pay_byte), .fcs(fcs),
        .rd_idx(rd_idx), .flush(flush), .active(rx_active), .idle(seq_idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ev_buf(ev_rx_buf), .ev_frame(ev_rx_frame)
    );
endmodule

// File: rtl/rx_bd_engine_chk.sv
module rx_bd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_active,
    input logic        in_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        ev_rx_buf,
    input logic        ev_rx_frame
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_active && !mem_req && !ev_rx_buf && !ev_rx_frame)); // R1
    AST_READY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> rx_active); // R2
    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'hF)); // R3
    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ev_rx_buf && ev_rx_frame)); // R6
    AST_FRAME_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        ev_rx_frame |-> $past(mem_req && mem_we && mem_ack)); // R6
    AST_NO_INPUT_DURING_DMA: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_ready); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata))); // R13
endmodule

bind rx_bd_engine rx_bd_engine_chk u_chk (.*);

// File: tb/rx_bd_engine_tb.sv
module rx_bd_engine_tb;
    localparam int MAXF = 2032;
    localparam int BW   = 11;
    localparam logic [31:0] BASE = 32'h100;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic [31:0]   ring_base = BASE;
    logic [BW-1:0] buf_size = BW'(64);
    logic [15:0]   frame_limit = 16'd1518;
    logic          ring_restart = 1'b0, rx_kick = 1'b0;
    logic          rx_active, in_ready;
    logic          in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0]   mem_addr, mem_wdata, mem_rdata = 32'h0;
    logic [3:0]    mem_be;
    logic          ev_rx_buf, ev_rx_frame;

    rx_bd_engine #(.MAX_FRAME(MAXF), .BW(BW)) u_dut (
        .clk(clk), .rst(rst), .ring_base(ring_base), .buf_size(buf_size),
        .frame_limit(frame_limit), .ring_restart(ring_restart), .rx_kick(rx_kick),
        .rx_active(rx_active), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ev_rx_buf(ev_rx_buf), .ev_rx_frame(ev_rx_frame)
    );

    logic [7:0] mem  [0:8191];
    logic [7:0] emem [0:8191];
    logic [7:0] pay  [0:2047];
    int checks = 0, fails = 0, n_buf = 0, n_frm = 0, e_buf = 0, e_frm = 0;
    logic [31:0] e_ptr = BASE;
    logic e_active = 1'b0;
    bit done = 1'b0;

    // memory slave and event counters, all at the inactive edge
    always @(negedge clk) begin
        int a;
        if (ev_rx_buf)   n_buf++;
        if (ev_rx_frame) n_frm++;
        mem_ack = 1'b0;
        if (!rst && mem_req && ($urandom % 4) != 0) begin
            a = int'(mem_addr[12:0]) & ~3;
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[3-k]) mem[a+k] = mem_wdata[31-8*k -: 8];
            end else begin
                mem_rdata = {mem[a], mem[a+1], mem[a+2], mem[a+3]};
            end
            mem_ack = 1'b1;
        end
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] erd16(input logic [31:0] a);
        return {emem[a[12:0]], emem[a[12:0]+1]};
    endfunction
    function automatic logic [31:0] erd32(input logic [31:0] a);
        return {emem[a[12:0]], emem[a[12:0]+1], emem[a[12:0]+2], emem[a[12:0]+3]};
    endfunction
    task automatic both16(input logic [31:0] a, input logic [15:0] v);
        emem[a[12:0]] = v[15:8]; emem[a[12:0]+1] = v[7:0];
        mem[a[12:0]]  = v[15:8]; mem[a[12:0]+1]  = v[7:0];
    endtask
    task automatic ewr16(input logic [31:0] a, input logic [15:0] v);
        emem[a[12:0]] = v[15:8]; emem[a[12:0]+1] = v[7:0];
    endtask

    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, pay[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // reference of R3..R11 applied to the expected memory image
    task automatic model_frame(input int n);
        int size, pos, ch, p;
        logic [15:0] ef, fl;
        logic [31:0] f, dp;
        size = n + 4; pos = 0; ef = 16'h0; f = ref_fcs(n);
        if (size > MAXF) begin size = MAXF; ef = 16'h0021; end
        if (size > int'(frame_limit)) ef = ef | 16'h0020;
        while (pos < size) begin
            fl = erd16(e_ptr);
            if (!fl[15]) break;
            ch = (size - pos < int'(buf_size)) ? size - pos : int'(buf_size);
            dp = erd32(e_ptr + 4);
            for (int k = 0; k < ch; k++) begin
                p = pos + k;
                emem[(int'(dp) + k) & 8191] = (p < size - 4) ? pay[p] : f[31-8*(p-(size-4)) -: 8];
            end
            pos += ch;
            fl[15] = 1'b0;
            if (pos == size) begin fl = fl | 16'h0800 | ef; e_frm++; end
            else e_buf++;
            ewr16(e_ptr, fl);
            ewr16(e_ptr + 2, 16'(ch));
            e_ptr = fl[13] ? BASE : e_ptr + 8;
        end
        fl = erd16(e_ptr);
        e_active = fl[15];
    endtask

    task automatic wait_quiet();
        int q;
        repeat (2) @(negedge clk);
        q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (mem_req) q = 0; else q++;
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < 8192; i++)
            if (bad < 0 && mem[i] !== emem[i]) bad = i;
        if (bad < 0) chk(tag, 1'b1, 0, 0);
        else chk($sformatf("%s mem[%0h]", tag, bad), 1'b0, mem[bad], emem[bad]);
    endtask

    task automatic pulse_ctl(input bit rs, input bit kk);
        ring_restart = rs; rx_kick = kk;
        @(negedge clk);
        ring_restart = 1'b0; rx_kick = 1'b0;
    endtask

    // ring of n descriptors, index full_idx not empty, last one wraps
    task automatic setup_ring(input int n, input int full_idx, input string tag);
        logic [15:0] fl;
        logic [31:0] dp;
        for (int i = 0; i < n; i++) begin
            fl = 16'($urandom) & 16'h5000;
            if (i != full_idx) fl[15] = 1'b1;
            if (i == n - 1)    fl[13] = 1'b1;
            dp = 32'h400 + 32'(i) * 32'h300;
            both16(BASE + 32'(8*i), fl);
            both16(BASE + 32'(8*i) + 2, 16'h0);
            both16(BASE + 32'(8*i) + 4, dp[31:16]);
            both16(BASE + 32'(8*i) + 6, dp[15:0]);
        end
        pulse_ctl(1'b1, 1'b1);
        e_ptr = BASE;
        fl = erd16(e_ptr);
        e_active = fl[15];
        wait_quiet();
        chk({tag, " active after kick"}, rx_active == e_active, rx_active, e_active);
    endtask

    task automatic send_frame(input int n, input string tag);
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = pay[i]; in_last = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        model_frame(n);
        wait_quiet();
        cmp_mem(tag);
        chk({tag, " R6 buffer events"}, n_buf == e_buf, n_buf, e_buf);
        chk({tag, " R6 frame events"}, n_frm == e_frm, n_frm, e_frm);
        chk({tag, " R11 reprobe"}, rx_active == e_active, rx_active, e_active);
        chk({tag, " R2 ready"}, in_ready == e_active, in_ready, e_active);
    endtask

    initial begin
        logic [15:0] fl;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8192; i++) begin mem[i] = 8'h0; emem[i] = 8'h0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset active", rx_active == 1'b0, rx_active, 0);
        chk("R1 reset ready", in_ready == 1'b0, in_ready, 0);
        chk("R1 reset req", mem_req == 1'b0, mem_req, 0);
        chk("R1 reset events", n_buf + n_frm == 0, n_buf + n_frm, 0);

        setup_ring(4, 0, "R2 full head");
        setup_ring(8, -1, "R12 restart");

        buf_size = BW'(64);
        send_frame(62, "R3/R4 crc spans buffers");
        send_frame(60, "R4 exact fit");
        send_frame(1, "R3 one byte");

        frame_limit = 16'd100;
        send_frame(150, "R9 over limit");
        send_frame(96, "R9 at limit");
        frame_limit = 16'd1518;

        setup_ring(8, -1, "R12 refill");
        buf_size = BW'(512);
        send_frame(2040, "R8 truncation");

        setup_ring(8, 2, "R10 setup");
        buf_size = BW'(32);
        send_frame(100, "R10 drop");
        chk("R10 inactive after drop", rx_active == 1'b0, rx_active, 0);
        pulse_ctl(1'b0, 1'b1);
        wait_quiet();
        chk("R2 kick on full stays low", rx_active == 1'b0, rx_active, 0);

        setup_ring(2, -1, "R7 setup");
        send_frame(20, "R7 first");
        send_frame(20, "R7 wrap");
        fl = erd16(BASE) | 16'h8000;
        both16(BASE, fl);
        e_active = 1'b1;
        pulse_ctl(1'b0, 1'b1);
        wait_quiet();
        chk("R7 wrapped pointer probe", rx_active == 1'b1, rx_active, 1);
        send_frame(30, "R7/R5 reuse after wrap");

        setup_ring(8, -1, "R12 random start");
        for (int t = 0; t < 25; t++) begin
            if (!e_active) setup_ring(8, -1, "R12 random refill");
            buf_size = BW'(16 + ($urandom % 285));
            send_frame(1 + int'($urandom % 400), "R3/R4/R5/R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R13 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule